// File: doc/BRIEF.md
# Reconfiguration Request and Poll Sequencer

This block is a small master that carries a transceiver streaming engine through one reconfiguration over that engine's memory-mapped register port. A one-cycle start request comes in with a 3-bit profile number. The sequencer first reads the control register. It then writes the same value back with three changes: the profile field is replaced, the broadcast bit is cleared, and the load bit is set. All other control bits keep the value that was read.

After that write the sequencer watches the status register. It waits a fixed number of clock cycles, reads the register, and looks only at its lowest bit, the busy flag. It repeats this wait-and-read pattern until busy reads as zero, then gives a one-cycle completion pulse. If busy is still set after a parameterised number of reads, the sequencer raises an error flag and returns to idle.

Each transfer follows a waitrequest handshake. The request, address and write data stay constant until the engine lowers waitrequest, and read data is taken in that same cycle.

Top module: `reconfig_poll_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, mm_rd, mm_wr, done_o, err_o and busy_o are all 0.
- R2: An accepted start makes the first transfer a read of the control register at address CTRL_ADDR (default 0x340).
- R3: The second transfer is a write to CTRL_ADDR. Its data is the value just read with bits [2:0] set to the profile, bit 6 set to 0 and bit 7 set to 1, and every other bit unchanged. For example, profile 1 over a read value of 0x00 gives 0x81.
- R4: While mm_wait is high, an active request keeps its strobe, address and write data unchanged. A transfer completes in the cycle in which mm_wait is low.
- R5: Every status read of address STAT_ADDR (default 0x341) starts after exactly POLL_GAP cycles with neither strobe active, counted from the completion of the previous transfer.
- R6: A status read that returns bit 0 equal to 0 produces a done_o pulse of exactly one cycle in the next cycle, and the sequencer goes back to idle. Status bits above bit 0 have no effect.
- R7: A status read that returns bit 0 equal to 1, while fewer than POLL_MAX status reads have been made, leads to another status read.
- R8: If POLL_MAX status reads in a row all return bit 0 equal to 1, err_o is set, no done_o pulse follows, and the sequencer goes idle. err_o stays high until the next accepted start clears it.
- R9: A start request while busy_o is high is ignored. The profile used is the one present when the start was accepted.
- R10: mm_rd and mm_wr are never high together. busy_o is high from the cycle after an accepted start until the sequencer returns to idle, and no strobe is active while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reconfiguration clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only when idle |
| profile_i | input | 3 | Profile number to load |
| mm_addr | output | ADDR_W | Transfer address |
| mm_rd | output | 1 | Read strobe |
| mm_wr | output | 1 | Write strobe |
| mm_wdata | output | DATA_W | Write data |
| mm_rdata | input | DATA_W | Read data, valid when mm_wait is low |
| mm_wait | input | 1 | Waitrequest; stalls the current transfer |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll limit reached; held until next accepted start |
| busy_o | output | 1 | Sequencer is not idle |

## Verification
The hardest situations to reach are the edges of the poll limit: busy clearing on exactly the last allowed read, and busy clearing one read too late. The bench's engine model returns busy for a programmed number of reads, so both edges can be set up directly. The model also holds waitrequest high for a programmed number of cycles on every transfer. This checks that the spacing between polls is measured from the completion of a stalled transfer. A second start is sent in the middle of a run with a different profile, and it must leave the expected transfer sequence unchanged.

// File: rtl/reconfig_seq_pkg.sv
package reconfig_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CRD  = 3'd1,
    S_CWR  = 3'd2,
    S_GAP  = 3'd3,
    S_SRD  = 3'd4
  } seq_state_t;

  localparam int PROF_W    = 3;
  localparam int BCAST_BIT = 6;
  localparam int LOAD_BIT  = 7;
endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int POLL_GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = $clog2(POLL_GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= CW'(POLL_GAP - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired_o = (cnt == '0);
endmodule

// File: rtl/seq_poll_count.sv
module seq_poll_count #(
  parameter int POLL_MAX = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt <= '0;
    end else if (inc_i) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last_o = (cnt == CW'(POLL_MAX - 1));
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import reconfig_seq_pkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h340,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h341
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PROF_W-1:0] profile_i,
  output logic [ADDR_W-1:0] mm_addr,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_wait,
  input  logic              gap_expired_i,
  input  logic              poll_last_i,
  output logic              gap_load_o,
  output logic              poll_clear_o,
  output logic              poll_inc_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    DATA_W'((1 << LOAD_BIT) | (1 << BCAST_BIT) | ((1 << PROF_W) - 1));
  localparam logic [DATA_W-1:0] LOAD_SET = DATA_W'(1 << LOAD_BIT);

  seq_state_t        state;
  logic [PROF_W-1:0] prof_q;
  logic              xfer_ok;
  logic              stat_busy;

  assign xfer_ok   = !mm_wait;
  assign stat_busy = mm_rdata[0];

  assign gap_load_o   = xfer_ok && ((state == S_CWR) ||
                        (state == S_SRD && stat_busy && !poll_last_i));
  assign poll_clear_o = xfer_ok && (state == S_CWR);
  assign poll_inc_o   = xfer_ok && (state == S_SRD) && stat_busy;
  assign busy_o       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      prof_q   <= '0;
      mm_addr  <= '0;
      mm_rd    <= 1'b0;
      mm_wr    <= 1'b0;
      mm_wdata <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            prof_q  <= profile_i;
            err_o   <= 1'b0;
            mm_rd   <= 1'b1;
            mm_addr <= CTRL_ADDR;
            state   <= S_CRD;
          end
        end
        S_CRD: begin
          if (xfer_ok) begin
            mm_rd    <= 1'b0;
            mm_wr    <= 1'b1;
            mm_wdata <= (mm_rdata & ~FIELD_MASK) | LOAD_SET | DATA_W'(prof_q);
            state    <= S_CWR;
          end
        end
        S_CWR: begin
          if (xfer_ok) begin
            mm_wr <= 1'b0;
            state <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_expired_i) begin
            mm_rd   <= 1'b1;
            mm_addr <= STAT_ADDR;
            state   <= S_SRD;
          end
        end
        S_SRD: begin
          if (xfer_ok) begin
            mm_rd <= 1'b0;
            if (!stat_busy) begin
              done_o <= 1'b1;
              state  <= S_IDLE;
            end else if (poll_last_i) begin
              err_o <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reconfig_poll_seq.sv
module reconfig_poll_seq #(
  parameter int                ADDR_W    = 10,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h340,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h341,
  parameter int                POLL_GAP  = 16,
  parameter int                POLL_MAX  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        profile_i,
  output logic [ADDR_W-1:0] mm_addr,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_wait,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  logic gap_load, gap_expired, poll_clear, poll_inc, poll_last;

  seq_ctrl_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .profile_i(profile_i),
    .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_wait(mm_wait),
    .gap_expired_i(gap_expired), .poll_last_i(poll_last),
    .gap_load_o(gap_load), .poll_clear_o(poll_clear), .poll_inc_o(poll_inc),
    .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
  );

  seq_gap_timer #(.POLL_GAP(POLL_GAP)) u_gap (
    .clk(clk), .rst(rst), .load_i(gap_load), .expired_o(gap_expired)
  );

  seq_poll_count #(.POLL_MAX(POLL_MAX)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(poll_clear), .inc_i(poll_inc),
    .last_o(poll_last)
  );
endmodule

// File: rtl/reconfig_poll_seq_chk.sv
module reconfig_poll_seq_chk #(
  parameter int                ADDR_W    = 10,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h340,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h341
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_rd,
  input logic              mm_wr,
  input logic [DATA_W-1:0] mm_wdata,
  input logic [DATA_W-1:0] mm_rdata,
  input logic              mm_wait,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_o
);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(mm_rd && mm_wr));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mm_rd && !mm_wr));

  assert_hold_rd_R4: assert property (@(posedge clk) disable iff (rst)
    (mm_rd && mm_wait) |=> (mm_rd && $stable(mm_addr)));

  assert_hold_wr_R4: assert property (@(posedge clk) disable iff (rst)
    (mm_wr && mm_wait) |=> (mm_wr && $stable(mm_addr) && $stable(mm_wdata)));

  assert_wr_fields_R3: assert property (@(posedge clk) disable iff (rst)
    mm_wr |-> (mm_addr == CTRL_ADDR && mm_wdata[7] && !mm_wdata[6]));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(mm_rd && !mm_wait && mm_addr == STAT_ADDR && !mm_rdata[0]));

  assert_err_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
endmodule

bind reconfig_poll_seq reconfig_poll_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr),
  .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_wait(mm_wait),
  .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
);

// File: tb/sim_reconfig_poll_seq.sv
`timescale 1ns/1ps
module sim_reconfig_poll_seq;
  localparam int GAP = 4;
  localparam int MAXP = 5;
  localparam logic [9:0] CA = 10'h340;
  localparam logic [9:0] SA = 10'h341;

  typedef struct {
    int         kind;
    logic [9:0] addr;
    logic [7:0] data;
  } exp_item_t;

  logic       clk = 0, rst = 1, start_i = 0, mm_wait = 0;
  logic [2:0] profile_i = 0;
  logic [7:0] mm_rdata = 0;
  logic [9:0] mm_addr;
  logic [7:0] mm_wdata;
  logic       mm_rd, mm_wr, done_o, err_o, busy_o;

  int checks = 0, errors = 0;
  exp_item_t expq[$];
  logic [7:0] ctrl_reg = 0;
  int busy_left = 0, stall_n = 0;
  bit live = 0;

  always #5 clk = ~clk;

  reconfig_poll_seq #(.POLL_GAP(GAP), .POLL_MAX(MAXP)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .profile_i(profile_i),
    .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_wait(mm_wait),
    .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [9:0] a, input logic [7:0] d);
    exp_item_t it;
    it.kind = k; it.addr = a; it.data = d;
    expq.push_back(it);
  endtask

  // engine model: waitrequest stalls and register contents
  initial begin
    int  cnt = 0;
    bit  prev_done = 0;
    forever begin
      @(negedge clk); #1;
      if (!(mm_rd || mm_wr)) begin
        mm_wait = 0; cnt = 0; prev_done = 0;
      end else begin
        if (prev_done) cnt = 0;
        mm_rdata = (mm_addr == CA) ? ctrl_reg : (8'hA4 | 8'(busy_left > 0));
        if (cnt < stall_n) begin
          mm_wait = 1; cnt++; prev_done = 0;
        end else begin
          mm_wait = 0; prev_done = 1;
          if (mm_wr) ctrl_reg = mm_wdata;
          if (mm_rd && mm_addr == SA && busy_left > 0) busy_left--;
        end
      end
    end
  end

  // monitor: pops expected items as transfers and events occur
  initial begin
    int  idle = 0;
    bit  rd_q = 0, err_q = 0;
    exp_item_t it;
    forever begin
      @(negedge clk); #4;
      if (live) begin
        if (mm_rd && !rd_q && mm_addr == SA)
          check(idle == GAP, "R5 poll spacing", idle, GAP);
        if (!mm_rd && !mm_wr) idle++; else idle = 0;
        if ((mm_rd || mm_wr) && !mm_wait) begin
          if (expq.size() == 0) check(0, "R2 unexpected transfer", mm_addr, 0);
          else begin
            it = expq.pop_front();
            check(it.kind == (mm_wr ? 1 : 0), "R2 transfer kind", mm_wr, it.kind);
            check(mm_addr == it.addr, "R2 transfer address", mm_addr, it.addr);
            if (mm_wr) check(mm_wdata == it.data, "R3 write data", mm_wdata, it.data);
          end
        end
        if (done_o || (err_o && !err_q)) begin
          if (expq.size() == 0) check(0, "R6 unexpected event", done_o, 0);
          else begin
            it = expq.pop_front();
            check(it.kind == (done_o ? 2 : 3), "R8 done or error outcome",
                  done_o ? 2 : 3, it.kind);
          end
          if (done_o) check(!err_o, "R8 err cleared by new start", err_o, 0);
        end
        rd_q = mm_rd; err_q = err_o;
      end
    end
  end

  task automatic run_case(input logic [2:0] prof, input logic [7:0] init,
                          input int busy_n, input int stall, input bit extra);
    int  nreads;
    bit  to;
    ctrl_reg = init; busy_left = busy_n; stall_n = stall;
    nreads = (busy_n + 1 > MAXP) ? MAXP : busy_n + 1;
    to = (busy_n + 1 > MAXP);
    push(0, CA, 0);
    push(1, CA, (init & 8'h38) | 8'h80 | {5'b0, prof});
    for (int i = 0; i < nreads; i++) push(0, SA, 0);
    push(to ? 3 : 2, 0, 0);
    @(negedge clk); start_i = 1; profile_i = prof;
    @(negedge clk); start_i = 0;
    @(negedge clk);
    check(busy_o, "R10 busy after start", busy_o, 1);
    if (extra) begin
      start_i = 1; profile_i = ~prof;
      @(negedge clk); start_i = 0;   // R9: must not alter the sequence
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R7 all expected items seen", expq.size(), 0);
    check(err_o == to, "R8 error flag level", err_o, to);
    check(!done_o, "R6 done is a pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mm_rd && !mm_wr && !done_o && !err_o && !busy_o, "R1 reset state",
          {mm_rd, mm_wr, done_o, err_o, busy_o}, 0);
    rst = 0;
    @(negedge clk);
    check(!mm_rd && !mm_wr && !busy_o, "R1 after reset", {mm_rd, mm_wr, busy_o}, 0);
    live = 1;
    run_case(3'd1, 8'h00, 2, 0, 0);  // R3 profile 1 -> 0x81
    run_case(3'd5, 8'h7E, 0, 2, 0);  // R4 stalls, R6 immediate idle
    run_case(3'd6, 8'hC1, 7, 1, 0);  // R8 timeout
    run_case(3'd3, 8'h38, 1, 0, 1);  // R9 ignored start, R8 clear
    run_case(3'd7, 8'hFF, 4, 3, 0);  // R7 busy clears on last allowed poll
    run_case(3'd0, 8'h00, 5, 0, 0);  // R8 one poll too many
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule